// File: doc/BRIEF.md
# UART Channel-Mode FIFO Router

This block holds the receive and transmit byte queues of a serial port and decides, cycle by cycle, where each byte goes. Bytes come from three places: host writes to the data register, bytes arriving from the receive deserializer (including a line-break indication), and the transmit queue, which the serializer empties through a valid/ready handshake. A two-bit channel mode selects the routing. Enable and disable bits in the control register gate each direction. Two further control bits flush the queues and clear themselves.

The routing is built around the channel-mode state register `mode_q`. Its four states are `CH_NORMAL`, `CH_ECHO`, `CH_LOCAL` and `CH_REMOTE`. Its single transition type is a host write to the mode register, which moves from any state to the state encoded in the written bits [9:8]; without such a write the state holds. A separate output decoder turns the state into four steering flags: incoming-to-RX, incoming-to-TX, host-to-RX and host-to-TX. The queue levels and a one-cycle overrun pulse go to the interrupt logic.

Top module: `uart_chan_router`

## Requirements
- R1: After reset the control register holds 0x128, so both directions are disabled. The mode is normal, both levels are zero, `ser_tx_valid` is low and `rx_overrun` is low.
- R2: A host write at byte offset 0x04 loads the mode from `host_wdata[9:8]`: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. An incoming byte enters the RX queue in normal and echo modes. It enters the TX queue in echo and remote loopback modes. In local loopback it is dropped.
- R3: A host write at offset 0x30 pushes `host_wdata[7:0]` into the TX queue in normal mode and into the RX queue in local loopback mode. In echo and remote loopback modes it is discarded.
- R4: A host write at offset 0x00 loads the control register. If bit 0 of the write is set, the RX queue empties on that edge. If bit 1 is set, the TX queue empties on that edge. Neither bit is retained, so later pushes are accepted.
- R5: RX is active only when control bit 2 is set and bit 3 is clear. TX is active only when bit 4 is set and bit 5 is clear. Pushes into an inactive queue are dropped. A data read while RX is inactive returns 0 and removes nothing.
- R6: A push that finds its queue full is dropped, and `rx_overrun` is high for exactly the following cycle. This applies to either queue and either source. Levels never exceed the depth.
- R7: A data read (offset 0x30) with an empty RX queue returns 0. The same combinational `host_rdata` returns the head byte when the queue holds data, and that byte is popped on the edge.
- R8: `ser_rx_break` pushes the byte 0x00 as an incoming byte, whatever `ser_rx_byte` holds.
- R9: Both queues are first-in first-out. `ser_tx_valid` is high whenever the TX level is nonzero, and a byte leaves on each edge where `ser_tx_valid` and `ser_tx_ready` are both high.
- R10: A push and a pop on the same queue in the same cycle leave its level unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 6 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 8 | Data-register read value (combinational) |
| ser_rx_valid | input | 1 | Incoming byte valid |
| ser_rx_byte | input | 8 | Incoming byte |
| ser_rx_break | input | 1 | Line break seen; pushes 0x00 |
| ser_tx_valid | output | 1 | TX queue has a byte for the serializer |
| ser_tx_byte | output | 8 | Head of the TX queue |
| ser_tx_ready | input | 1 | Serializer accepts the head byte |
| rx_level | output | $clog2(RX_DEPTH+1) | RX queue occupancy |
| tx_level | output | $clog2(TX_DEPTH+1) | TX queue occupancy |
| rx_overrun | output | 1 | One-cycle pulse after a dropped push into a full queue |

## Verification
The bench builds the router with both depths set to 4 instead of the default 64. With that depth, a few pushes fill either queue, which brings the full-queue drop and the overrun pulse within reach. It also brings pointer wraparound and flushes of a partly filled queue within reach. The small depth also lets every mode state be visited with pushes from both sources, so every steering flag is observed through the levels and the read data.

// File: rtl/uart_chan_router_pkg.sv
package uart_chan_router_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LOCAL  = 2'd2,
        CH_REMOTE = 2'd3
    } chan_mode_e;

    typedef struct packed {
        logic in_to_rx;
        logic in_to_tx;
        logic host_to_rx;
        logic host_to_tx;
    } route_t;

    localparam logic [5:0] OFS_CTRL = 6'h00;
    localparam logic [5:0] OFS_MODE = 6'h04;
    localparam logic [5:0] OFS_DATA = 6'h30;

    localparam logic [8:0] CTRL_RESET = 9'h128;

    localparam int CB_RX_FLUSH = 0;
    localparam int CB_TX_FLUSH = 1;
    localparam int CB_RX_EN    = 2;
    localparam int CB_RX_DIS   = 3;
    localparam int CB_TX_EN    = 4;
    localparam int CB_TX_DIS   = 5;

endpackage

// File: rtl/chan_route_decode.sv
module chan_route_decode
    import uart_chan_router_pkg::*;
(
    input  chan_mode_e mode,
    output route_t     route
);

    always_comb begin
        route = '0;
        unique case (mode)
            CH_NORMAL: begin
                route.in_to_rx   = 1'b1;
                route.host_to_tx = 1'b1;
            end
            CH_ECHO: begin
                route.in_to_rx = 1'b1;
                route.in_to_tx = 1'b1;
            end
            CH_LOCAL: begin
                route.host_to_rx = 1'b1;
            end
            CH_REMOTE: begin
                route.in_to_tx = 1'b1;
            end
            default: route = '0;
        endcase
    end

endmodule

// File: rtl/router_byte_fifo.sv
module router_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
    import uart_chan_router_pkg::*;
#(
    parameter int RX_DEPTH = 64,
    parameter int TX_DEPTH = 64,
    localparam int RXCW = $clog2(RX_DEPTH + 1),
    localparam int TXCW = $clog2(TX_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic [5:0]      host_addr,
    input  logic [31:0]     host_wdata,
    output logic [7:0]      host_rdata,
    input  logic            ser_rx_valid,
    input  logic [7:0]      ser_rx_byte,
    input  logic            ser_rx_break,
    output logic            ser_tx_valid,
    output logic [7:0]      ser_tx_byte,
    input  logic            ser_tx_ready,
    output logic [RXCW-1:0] rx_level,
    output logic [TXCW-1:0] tx_level,
    output logic            rx_overrun
);

    chan_mode_e mode_q;
    chan_mode_e mode_d;
    route_t     route;
    logic [8:0] ctrl_q;

    logic wr_ctrl, wr_mode, wr_data, rd_data;
    logic rx_on, tx_on;
    logic in_evt;
    logic [7:0] in_byte;
    logic rx_push, tx_push, rx_pop, tx_pop;
    logic rx_flush, tx_flush;
    logic [7:0] rx_din, tx_din, rx_head;
    logic rx_full, rx_empty, tx_full, tx_empty;

    assign wr_ctrl = host_wr && (host_addr == OFS_CTRL);
    assign wr_mode = host_wr && (host_addr == OFS_MODE);
    assign wr_data = host_wr && (host_addr == OFS_DATA);
    assign rd_data = host_rd && (host_addr == OFS_DATA);

    // Mode state: next-state selection
    always_comb begin
        mode_d = mode_q;
        if (wr_mode) begin
            mode_d = chan_mode_e'(host_wdata[9:8]);
        end
    end

    // Mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= CH_NORMAL;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Mode state outputs: steering flags
    chan_route_decode u_route (
        .mode  (mode_q),
        .route (route)
    );

    // Control register; flush bits are never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_ctrl) begin
            ctrl_q <= host_wdata[8:0] & ~9'b11;
        end
    end

    assign rx_on    = ctrl_q[CB_RX_EN] && !ctrl_q[CB_RX_DIS];
    assign tx_on    = ctrl_q[CB_TX_EN] && !ctrl_q[CB_TX_DIS];
    assign rx_flush = wr_ctrl && host_wdata[CB_RX_FLUSH];
    assign tx_flush = wr_ctrl && host_wdata[CB_TX_FLUSH];

    assign in_evt  = ser_rx_valid || ser_rx_break;
    assign in_byte = ser_rx_break ? 8'h00 : ser_rx_byte;

    assign rx_push = rx_on && ((in_evt && route.in_to_rx) || (wr_data && route.host_to_rx));
    assign tx_push = tx_on && ((in_evt && route.in_to_tx) || (wr_data && route.host_to_tx));
    assign rx_din  = (wr_data && route.host_to_rx) ? host_wdata[7:0] : in_byte;
    assign tx_din  = (wr_data && route.host_to_tx) ? host_wdata[7:0] : in_byte;

    assign rx_pop = rd_data && rx_on;
    assign tx_pop = ser_tx_valid && ser_tx_ready;

    router_byte_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_push),
        .din   (rx_din),
        .pop   (rx_pop),
        .head  (rx_head),
        .count (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    router_byte_fifo #(.DEPTH(TX_DEPTH), .WIDTH(8)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push),
        .din   (tx_din),
        .pop   (tx_pop),
        .head  (ser_tx_byte),
        .count (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    assign ser_tx_valid = !tx_empty;
    assign host_rdata   = (rd_data && rx_on && !rx_empty) ? rx_head : 8'h00;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_overrun <= 1'b0;
        end else begin
            rx_overrun <= (rx_push && rx_full && !rx_flush)
                       || (tx_push && tx_full && !tx_flush);
        end
    end

endmodule

// File: rtl/uart_chan_router_chk.sv
module uart_chan_router_chk
    import uart_chan_router_pkg::*;
#(
    parameter int RX_DEPTH = 64,
    parameter int TX_DEPTH = 64,
    localparam int RXCW = $clog2(RX_DEPTH + 1),
    localparam int TXCW = $clog2(TX_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_wr,
    input logic            host_rd,
    input logic [5:0]      host_addr,
    input logic [31:0]     host_wdata,
    input logic [7:0]      host_rdata,
    input logic            ser_tx_ready,
    input logic [RXCW-1:0] rx_level,
    input logic [TXCW-1:0] tx_level,
    input logic            rx_overrun,
    input logic            rx_on,
    input chan_mode_e      mode_q
);

    p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= RXCW'(RX_DEPTH)) && (tx_level <= TXCW'(TX_DEPTH)));

    p_overrun_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> $past(rx_level == RXCW'(RX_DEPTH) || tx_level == TXCW'(TX_DEPTH)));

    p_rx_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_CTRL && host_wdata[0]) |=> (rx_level == '0));

    p_tx_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_CTRL && host_wdata[1]) |=> (tx_level == '0));

    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_DATA && rx_level == '0) |-> (host_rdata == 8'h00));

    p_off_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_DATA && !rx_on) |-> (host_rdata == 8'h00));

    p_local_no_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CH_LOCAL) |=> (tx_level <= $past(tx_level)));

endmodule

bind uart_chan_router uart_chan_router_chk #(
    .RX_DEPTH(RX_DEPTH),
    .TX_DEPTH(TX_DEPTH)
) u_chk (.*);

// File: tb/tb_uart_chan_router.sv
module tb_uart_chan_router;

    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        ser_rx_valid = 1'b0;
    logic [7:0]  ser_rx_byte = '0;
    logic        ser_rx_break = 1'b0;
    logic        ser_tx_valid;
    logic [7:0]  ser_tx_byte;
    logic        ser_tx_ready = 1'b0;
    logic [2:0]  rx_level;
    logic [2:0]  tx_level;
    logic        rx_overrun;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_chan_router #(.RX_DEPTH(D), .TX_DEPTH(D)) dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic levels(input string req, input int erx, input int etx);
        check(rx_level == erx, {req, " rx_level"}, rx_level, erx);
        check(tx_level == etx, {req, " tx_level"}, tx_level, etx);
    endtask

    task automatic hw(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input string req, input logic [7:0] exp);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 6'h30;
        #1;
        check(host_rdata == exp, req, host_rdata, exp);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rx_in(input logic [7:0] b, input bit brk);
        @(negedge clk);
        ser_rx_valid = !brk; ser_rx_break = brk; ser_rx_byte = b;
        @(negedge clk);
        ser_rx_valid = 1'b0; ser_rx_break = 1'b0;
    endtask

    task automatic tx_take(input string req, input logic [7:0] exp);
        @(negedge clk);
        check(ser_tx_valid == 1'b1, {req, " tx_valid"}, ser_tx_valid, 1);
        check(ser_tx_byte == exp, {req, " tx_byte"}, ser_tx_byte, exp);
        ser_tx_ready = 1'b1;
        @(negedge clk);
        ser_tx_ready = 1'b0;
    endtask

    task automatic t_reset;
        levels("R1 reset", 0, 0);
        check(ser_tx_valid == 0, "R1 tx_valid", ser_tx_valid, 0);
        check(rx_overrun == 0, "R1 overrun", rx_overrun, 0);
        hw(6'h30, 32'h11);
        rx_in(8'h22, 0);
        levels("R1 R5 disabled after reset", 0, 0);
        hw(6'h00, 32'h14);
    endtask

    task automatic t_modes;
        rx_in(8'hA1, 0); rx_in(8'hA2, 0);
        levels("R2 normal incoming", 2, 0);
        hw(6'h30, 32'hC3);
        levels("R3 normal host", 2, 1);
        hread("R9 rx order first", 8'hA1);
        hread("R9 rx order second", 8'hA2);
        hread("R7 empty read", 8'h00);
        hw(6'h04, 32'h100);
        rx_in(8'hD4, 0);
        levels("R2 echo incoming", 1, 2);
        hw(6'h30, 32'hE5);
        levels("R3 echo host dropped", 1, 2);
        tx_take("R9 tx order first", 8'hC3);
        tx_take("R9 tx order second", 8'hD4);
        check(ser_tx_valid == 0, "R9 tx drained", ser_tx_valid, 0);
        hread("R2 echo rx copy", 8'hD4);
        hw(6'h04, 32'h200);
        hw(6'h30, 32'hF6);
        levels("R3 local host", 1, 0);
        rx_in(8'h77, 0);
        levels("R2 local incoming dropped", 1, 0);
        hread("R3 local byte", 8'hF6);
        hw(6'h04, 32'h300);
        rx_in(8'h88, 0);
        levels("R2 remote incoming", 0, 1);
        hw(6'h30, 32'h99);
        levels("R3 remote host dropped", 0, 1);
        tx_take("R2 remote byte", 8'h88);
        hw(6'h04, 32'h000);
    endtask

    task automatic t_flush;
        rx_in(8'h01, 0); rx_in(8'h02, 0); hw(6'h30, 32'h03);
        levels("R4 prefill", 2, 1);
        hw(6'h00, 32'h15);
        levels("R4 rx flush", 0, 1);
        rx_in(8'h44, 0);
        levels("R4 self clear rx", 1, 1);
        hw(6'h00, 32'h16);
        levels("R4 tx flush", 1, 0);
        hw(6'h30, 32'h55);
        levels("R4 self clear tx", 1, 1);
        tx_take("R4 tx after flush", 8'h55);
        hread("R4 rx after flush", 8'h44);
    endtask

    task automatic t_overflow;
        for (int i = 1; i <= D; i++) rx_in(8'(i), 0);
        check(rx_overrun == 0, "R6 no overrun at fill", rx_overrun, 0);
        rx_in(8'h5A, 0);
        check(rx_overrun == 1, "R6 rx overrun pulse", rx_overrun, 1);
        levels("R6 rx full kept", D, 0);
        @(negedge clk);
        check(rx_overrun == 0, "R6 pulse one cycle", rx_overrun, 0);
        hread("R6 head kept", 8'h01);
        hw(6'h00, 32'h15);
        for (int i = 1; i <= D; i++) hw(6'h30, 32'(8'h60 + i));
        hw(6'h30, 32'h6F);
        check(rx_overrun == 1, "R6 tx overrun pulse", rx_overrun, 1);
        levels("R6 tx full kept", 0, D);
        hw(6'h00, 32'h16);
    endtask

    task automatic t_break;
        rx_in(8'hFF, 1);
        levels("R8 break push", 1, 0);
        hread("R8 break byte", 8'h00);
        levels("R8 popped", 0, 0);
    endtask

    task automatic t_disable;
        rx_in(8'h66, 0);
        hw(6'h00, 32'h1C);
        rx_in(8'h67, 0);
        levels("R5 rx disabled push", 1, 0);
        hread("R5 rx disabled read", 8'h00);
        levels("R5 no pop", 1, 0);
        hw(6'h00, 32'h14);
        hread("R5 rx reenabled", 8'h66);
        hw(6'h00, 32'h34);
        hw(6'h30, 32'h12);
        levels("R5 tx disabled push", 0, 0);
        hw(6'h00, 32'h14);
    endtask

    task automatic t_simul;
        hw(6'h30, 32'h31);
        @(negedge clk);
        ser_tx_ready = 1'b1; host_wr = 1'b1; host_addr = 6'h30; host_wdata = 32'h32;
        @(negedge clk);
        ser_tx_ready = 1'b0; host_wr = 1'b0;
        levels("R10 tx push+pop", 0, 1);
        tx_take("R10 tx order", 8'h32);
        rx_in(8'h41, 0);
        @(negedge clk);
        ser_rx_valid = 1'b1; ser_rx_byte = 8'h42; host_rd = 1'b1; host_addr = 6'h30;
        #1;
        check(host_rdata == 8'h41, "R10 rx read during push", host_rdata, 8'h41);
        @(negedge clk);
        ser_rx_valid = 1'b0; host_rd = 1'b0;
        levels("R10 rx push+pop", 1, 0);
        hread("R10 rx order", 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_flush();
        t_overflow();
        t_break();
        t_disable();
        t_simul();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule